// File: doc/BRIEF.md
# Receive Byte Queue with Sticky Overrun Flag

This block sits behind a serial deserializer. Each completed byte arrives with a one-cycle valid strobe and is stored in a 16-entry first-in first-out queue. A CPU-side read port pops the oldest byte and sees it on a registered data output. The port also shows the current fill count and an empty indication.

A 16-bit status register holds one sticky overrun flag in bit 0. The flag sets when a byte completes while the queue is already full and no pop happens in the same cycle. That byte is dropped and the stored bytes stay as they were. While the flag is set, no further bytes enter the queue.

Software clears the flag in two steps. First it reads the register while the flag is 1, which arms the clear. Then it writes 0 to bit 0. Writing 1 has no effect. Turning off the receive enable blocks intake but leaves the flag alone.

Top module: `rxq_status_top`

## Requirements
- R1: After a synchronous reset, the fill count is 0, empty is 1, read data is 0x00, the overrun flag is 0, and a register read returns 0x0000.
- R2: Popped bytes leave in the order they were accepted. A byte appears on rd_data in the cycle after the pop strobe.
- R3: rd_count equals the number of stored bytes and rd_empty is 1 exactly when that number is 0. A pop while empty changes neither the count nor rd_data.
- R4: If a byte arrives with rx_en=1, the queue holds 16 bytes, no pop occurs and the flag is 0, then the flag reads 1 from the next cycle on. That byte is dropped and the 16 stored bytes come out unchanged.
- R5: If a byte arrives while the queue is full and a pop occurs in the same cycle, the byte is accepted. The count stays at 16 and the flag stays 0.
- R6: While the flag is 1, arriving bytes are not stored. Pops still drain the queue and lower the count.
- R7: A register write with bit 0 equal to 1 never sets the flag and never clears it.
- R8: A write of 0 to bit 0 clears the flag only if the register was read while the flag was 1 and no clear has happened since that read. Otherwise the flag stays 1.
- R9: With rx_en=0, arriving bytes are ignored. The level of rx_en does not change the flag.
- R10: A register read returns the flag in bit 0 and zeros in bits 15 to 1 on reg_rdata in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receive enable; 0 blocks intake |
| rx_valid | input | 1 | One-cycle strobe: a received byte is complete |
| rx_byte | input | 8 | Received byte |
| rd_pop | input | 1 | CPU pops the oldest byte |
| rd_data | output | 8 | Byte from the last successful pop (registered) |
| rd_empty | output | 1 | Queue holds no bytes |
| rd_count | output | 5 | Number of stored bytes, 0 to 16 |
| reg_rd | input | 1 | Status register read strobe |
| reg_wr | input | 1 | Status register write strobe |
| reg_wbit | input | 1 | Write data for bit 0; bits 15 to 1 have no storage |
| reg_rdata | output | 16 | Status register read data, valid the cycle after reg_rd |

## Verification
The hardest state to reach is a set flag whose clear has already been used up. To get there, the stimulus overruns the queue, reads the flag and clears it, then drains the queue partway and refills it to force a second overrun. A write of 0 with no fresh read must then leave the flag set. The stimulus also fills the queue to exactly 16 and strikes a push and a pop in the same cycle, which must not count as an overrun. Bursts of every length from 1 to 16 are pushed and drained, and each one is compared with a queue model held in the bench.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int unsigned STAT_W  = 16;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned OVR_BIT = 0;

  function automatic logic [STAT_W-1:0] stat_word(input logic ovr);
    logic [STAT_W-1:0] w;
    w = '0;
    w[OVR_BIT] = ovr;
    return w;
  endfunction
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned DW    = 8,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] pop_data,
  output logic [CW-1:0] count,
  output logic          empty,
  output logic          full
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt_q, cnt_d;

  // storage: write port only, no reset, so a RAM can be inferred
  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pop_data <= '0;
    end else if (pop) begin
      pop_data <= mem[rd_ptr];
    end
  end

  always_comb begin
    cnt_d = cnt_q;
    if (push && !pop) cnt_d = cnt_q + 1'b1;
    else if (pop && !push) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
      empty  <= 1'b1;
      full   <= 1'b0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      cnt_q <= cnt_d;
      empty <= (cnt_d == '0);
      full  <= (cnt_d == FULL_CNT);
    end
  end

  assign count = cnt_q;
endmodule

// File: rtl/rxq_ovr_flag.sv
module rxq_ovr_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_ev,
  input  logic rd_strobe,
  input  logic wr_strobe,
  input  logic wr_bit,
  output logic flag,
  output logic armed
);
  logic clear_ok;

  // clear only with a 0 write after the flag was seen as 1
  assign clear_ok = wr_strobe && !wr_bit && armed && flag;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag  <= 1'b0;
      armed <= 1'b0;
    end else begin
      if (set_ev) begin
        flag  <= 1'b1;
        armed <= 1'b0;
      end else if (clear_ok) begin
        flag  <= 1'b0;
        armed <= 1'b0;
      end else begin
        armed <= flag && (armed || rd_strobe);
      end
    end
  end
endmodule

// File: rtl/rxq_status_top.sv
module rxq_status_top #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      rx_en,
  input  logic                      rx_valid,
  input  logic [rxq_pkg::BYTE_W-1:0] rx_byte,
  input  logic                      rd_pop,
  output logic [rxq_pkg::BYTE_W-1:0] rd_data,
  output logic                      rd_empty,
  output logic [CW-1:0]             rd_count,
  input  logic                      reg_rd,
  input  logic                      reg_wr,
  input  logic                      reg_wbit,
  output logic [rxq_pkg::STAT_W-1:0] reg_rdata
);
  import rxq_pkg::*;

  logic q_full, q_empty;
  logic pop_ok, push_ok, arrive, ovr_ev;
  logic ovr_flag, ovr_armed;

  assign arrive  = rx_valid && rx_en && !ovr_flag;
  assign pop_ok  = rd_pop && !q_empty;
  assign push_ok = arrive && (!q_full || pop_ok);
  assign ovr_ev  = arrive && q_full && !pop_ok;

  rxq_store #(.DEPTH(DEPTH), .DW(BYTE_W)) u_store (
    .clk       (clk),
    .rst       (rst),
    .push      (push_ok),
    .push_data (rx_byte),
    .pop       (pop_ok),
    .pop_data  (rd_data),
    .count     (rd_count),
    .empty     (q_empty),
    .full      (q_full)
  );

  rxq_ovr_flag u_flag (
    .clk       (clk),
    .rst       (rst),
    .set_ev    (ovr_ev),
    .rd_strobe (reg_rd),
    .wr_strobe (reg_wr),
    .wr_bit    (reg_wbit),
    .flag      (ovr_flag),
    .armed     (ovr_armed)
  );

  assign rd_empty = q_empty;

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= stat_word(ovr_flag);
  end
endmodule

// File: rtl/rxq_status_chk.sv
module rxq_status_chk #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          rx_en,
  input logic          rx_valid,
  input logic          rd_pop,
  input logic          rd_empty,
  input logic [CW-1:0] rd_count,
  input logic          reg_rd,
  input logic          reg_wr,
  input logic          reg_wbit,
  input logic [15:0]   reg_rdata,
  input logic          ovr
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  assert_count_bound_R3: assert property (@(posedge clk) disable iff (rst)
    rd_count <= FULL_CNT);

  assert_empty_tracks_R3: assert property (@(posedge clk) disable iff (rst)
    rd_empty == (rd_count == '0));

  assert_overrun_sets_R4: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && rx_en && !ovr && rd_count == FULL_CNT && !rd_pop) |=> ovr);

  assert_full_pushpop_R5: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && rx_en && !ovr && rd_count == FULL_CNT && rd_pop) |=> (!ovr && rd_count == FULL_CNT));

  assert_intake_frozen_R6: assert property (@(posedge clk) disable iff (rst)
    (ovr && !rd_pop) |=> $stable(rd_count));

  assert_no_write_set_R7: assert property (@(posedge clk) disable iff (rst)
    (!ovr && !rx_valid) |=> !ovr);

  assert_clear_by_zero_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(ovr) |-> $past(reg_wr && !reg_wbit));

  assert_rxen_off_R9: assert property (@(posedge clk) disable iff (rst)
    (!rx_en && !rd_pop) |=> $stable(rd_count));

  assert_upper_zero_R10: assert property (@(posedge clk) disable iff (rst)
    reg_rdata[15:1] == 15'd0);

  assert_read_value_R10: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && !reg_wr) |=> (reg_rdata[0] == $past(ovr)));
endmodule

bind rxq_status_top rxq_status_chk #(.DEPTH(DEPTH)) i_chk (
  .clk       (clk),
  .rst       (rst),
  .rx_en     (rx_en),
  .rx_valid  (rx_valid),
  .rd_pop    (rd_pop),
  .rd_empty  (rd_empty),
  .rd_count  (rd_count),
  .reg_rd    (reg_rd),
  .reg_wr    (reg_wr),
  .reg_wbit  (reg_wbit),
  .reg_rdata (reg_rdata),
  .ovr       (ovr_flag)
);

// File: tb/test_rxq_status_top.sv
`timescale 1ns/1ps
module test_rxq_status_top;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_en = 1'b0, rx_valid = 1'b0, rd_pop = 1'b0;
  logic [7:0] rx_byte = '0;
  logic [7:0] rd_data;
  logic rd_empty;
  logic [4:0] rd_count;
  logic reg_rd = 1'b0, reg_wr = 1'b0, reg_wbit = 1'b0;
  logic [15:0] reg_rdata;

  int checks = 0, fails = 0;
  bit done = 0;

  // bench model
  byte unsigned q[$];
  bit eflag = 0, earm = 0;
  logic [7:0] elast = 8'h00;

  always #2.5 clk = ~clk;

  rxq_status_top #(.DEPTH(DEPTH)) i_rxq_status_top (
    .clk(clk), .rst(rst), .rx_en(rx_en), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .rd_pop(rd_pop), .rd_data(rd_data), .rd_empty(rd_empty), .rd_count(rd_count),
    .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_wbit(reg_wbit), .reg_rdata(reg_rdata)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // one cycle on the receive/read side; model updated from the requirements
  task automatic step(input string req, input bit v, input byte unsigned b, input bit p);
    bit arrive, popok, acc;
    arrive = v && rx_en && !eflag;
    popok  = p && (q.size() > 0);
    acc    = arrive && ((q.size() < DEPTH) || popok);
    if (arrive && q.size() == DEPTH && !popok) begin
      eflag = 1;
      earm  = 0;
    end
    if (popok) elast = q.pop_front();
    if (acc) q.push_back(b);
    @(negedge clk);
    rx_valid = v; rx_byte = b; rd_pop = p;
    @(negedge clk);
    rx_valid = 0; rd_pop = 0;
    chk(req, "count", rd_count, q.size());
    chk(req, "empty", rd_empty, q.size() == 0);
    chk(req, "rd_data", rd_data, elast);
  endtask

  task automatic reg_read(input string req);
    earm = earm | eflag;
    @(negedge clk); reg_rd = 1;
    @(negedge clk); reg_rd = 0;
    chk(req, "reg_rdata", reg_rdata, {15'd0, eflag});
  endtask

  task automatic reg_write(input bit d);
    if (!d && earm && eflag) begin eflag = 0; earm = 0; end
    @(negedge clk); reg_wr = 1; reg_wbit = d;
    @(negedge clk); reg_wr = 0; reg_wbit = 0;
  endtask

  task automatic fill_to(input string req, input int n, input int seed);
    while (q.size() < n) step(req, 1, byte'(seed + 7 * q.size()), 0);
  endtask

  task automatic drain(input string req);
    while (q.size() > 0) step(req, 0, 8'h00, 1);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1", "count", rd_count, 0);
    chk("R1", "empty", rd_empty, 1);
    chk("R1", "rd_data", rd_data, 0);
    chk("R1", "reg_rdata", reg_rdata, 0);
    reg_read("R1");

    rx_en = 1;
    // R3 pop on empty ignored
    step("R3", 0, 8'h00, 1);
    step("R3", 0, 8'h00, 1);

    // R2 R3 bursts of every length
    for (int n = 1; n <= DEPTH; n++) begin
      fill_to("R2", n, n * 17);
      drain("R2");
      step("R3", 0, 8'h00, 1);
    end

    // R2 interleaved push/pop
    for (int i = 0; i < 40; i++) step("R2", (i % 3) != 2, byte'(i * 29 + 3), (i % 2) == 1);
    drain("R2");

    // R5 simultaneous push and pop at full
    fill_to("R5", DEPTH, 8'h40);
    step("R5", 1, 8'hA5, 1);
    step("R5", 1, 8'h5A, 1);
    reg_read("R5");

    // R4 overrun: byte dropped, contents kept
    step("R4", 1, 8'hEE, 0);
    chk("R4", "flag model", eflag, 1);
    // R6 intake blocked while set, pops still work
    step("R6", 1, 8'hDD, 0);
    step("R6", 0, 8'h00, 1);
    step("R6", 1, 8'hCC, 0);
    // R9 rx_en does not touch the flag
    rx_en = 0;
    step("R9", 1, 8'hBB, 0);
    rx_en = 1;
    // R8 write 0 without a prior read leaves flag
    reg_write(0);
    reg_read("R8");
    // R7 write 1 does nothing (armed by read above)
    reg_write(1);
    reg_read("R7");
    // R8 armed clear
    reg_write(0);
    reg_read("R8");
    // R10 read value after all-ones style write
    reg_write(1);
    reg_read("R10");
    drain("R4");

    // R8 clear consumed: second overrun needs a new read
    fill_to("R8", DEPTH, 8'h11);
    step("R8", 1, 8'h99, 0);
    reg_read("R8");
    reg_write(0);
    reg_read("R8");
    step("R8", 0, 8'h00, 1);
    fill_to("R8", DEPTH, 8'h23);
    step("R8", 1, 8'h77, 0);
    reg_write(0);
    chk("R8", "flag model", eflag, 1);
    reg_read("R8");
    reg_write(0);
    reg_read("R8");

    // R9 rx_en low ignores bytes, flag stays clear
    drain("R9");
    rx_en = 0;
    for (int i = 0; i < 20; i++) step("R9", 1, byte'(i), 0);
    reg_read("R9");
    rx_en = 1;
    fill_to("R9", 3, 8'h61);
    drain("R9");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule